// File: doc/BRIEF.md
# Pipeline Read-After-Write Interlock

This block sits beside the decode stage of an in-order five-stage pipeline (fetch, decode with register read, execute, memory, writeback). Every cycle it takes the two source register numbers of the instruction in decode and compares each one with the destination register held in the execute, memory and writeback latches. When one of those producers will deliver its result too late for the consumer, the block asks for a stall. The stall holds the program counter and the fetch/decode latch, and it turns the next execute-stage slot into a no-op by clearing the control word that decode would have passed down.

A match only counts when both sides take part. The producer must actually write the register file, the consumer must actually read that operand, and the register must not be register 0, which always reads as zero. Only read-after-write dependences are checked: in this pipeline every read happens before every write of a later instruction, so write-after-read and write-after-write ordering cannot break. With result bypassing enabled, the only case that needs a stall is a load in execute whose destination is needed by the instruction directly behind it. That case costs exactly one cycle, and after it the loaded value is bypassed. With bypassing disabled, the block stalls until the producer has written the register file. A flush of the decode stage cancels any stall request, so a killed instruction cannot hold the pipe.

Top module: `raw_interlock`

## Requirements
- R1: When no qualified register match exists, pc_we=1, ifid_we=1, idex_bubble=0, and idex_ctrl equals id_ctrl.
- R2: A destination or source register number equal to 0 never produces a stall.
- R3: A producer whose register-write flag is 0 (for example a store) never produces a stall, even when its destination number matches a source.
- R4: A source whose read flag is 0 (for example the second operand of an immediate-form op, or a jump) never produces a stall for that source.
- R5: With BYPASS_EN=1, a load in the execute stage (ex_load=1, ex_rf_wr=1) whose destination matches a read source gives pc_we=0, ifid_we=0 and idex_bubble=1.
- R6: With BYPASS_EN=1, a matching non-load producer in execute, or any matching producer in the memory or writeback stage, gives no stall.
- R7: With BYPASS_EN=1, a load-use dependence stalls for exactly one cycle. After the load advances to the memory stage and a bubble fills execute, the same decode instruction sees no stall.
- R8: With BYPASS_EN=0, a match against the execute or memory stage stalls. A match against the writeback stage stalls only when RF_WRITE_FIRST=0.
- R9: While stalling, idex_ctrl is all zeros. Otherwise it equals id_ctrl.
- R10: While id_flush=1, no stall is requested: pc_we=1, ifid_we=1, idex_bubble=0, idex_ctrl equals id_ctrl.
- R11: pc_we and ifid_we are always equal, and idex_bubble is always their inverse.
- R12: Both decode sources are checked independently, so a match on the second source alone produces a stall just as a match on the first does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_W | First source register number of the decode instruction |
| id_rs2 | input | REG_W | Second source register number of the decode instruction |
| id_rs1_rd | input | 1 | Decode instruction really reads its first source |
| id_rs2_rd | input | 1 | Decode instruction really reads its second source |
| id_flush | input | 1 | Decode stage is being flushed this cycle |
| id_ctrl | input | CTRL_W | Control word decoded for the execute stage |
| ex_rd | input | REG_W | Destination register in the ID/EX latch |
| ex_rf_wr | input | 1 | ID/EX instruction writes the register file |
| ex_load | input | 1 | ID/EX instruction is a load |
| mem_rd | input | REG_W | Destination register in the EX/MEM latch |
| mem_rf_wr | input | 1 | EX/MEM instruction writes the register file |
| wb_rd | input | REG_W | Destination register in the MEM/WB latch |
| wb_rf_wr | input | 1 | MEM/WB instruction writes the register file |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID latch write enable |
| idex_bubble | output | 1 | Select a zero control word into ID/EX |
| idex_ctrl | output | CTRL_W | Control word to load into ID/EX |

## Verification
The bench drives three copies of the block from one shared pipeline-latch model. The first copy has bypassing on. The second has bypassing off with a register file that reads before it writes. The third has bypassing off with a register file that writes before it reads. This lets one stimulus show the load-only stall policy, the stall-until-written policy, and whether a writeback-stage match matters, all side by side. Register width stays at 5 and the control word at 8 bits. Register 31 and register 0 are used as boundary specifiers.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Number of producer latches compared against decode: ID/EX, EX/MEM, MEM/WB.
    localparam int N_PROD = 3;

    typedef enum logic [1:0] {
        PROD_EX  = 2'd0,
        PROD_MEM = 2'd1,
        PROD_WB  = 2'd2
    } prod_stage_e;

    // Per-producer match result, one bit per decode source operand.
    typedef struct packed {
        logic src_a;
        logic src_b;
    } src_hit_t;

    function automatic logic any_hit(input src_hit_t h);
        return h.src_a | h.src_b;
    endfunction

endpackage

// File: rtl/hz_cmp_slice.sv
module hz_cmp_slice
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dst,
    input  logic             dst_wr,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_rd,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_rd,
    output src_hit_t         hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic dst_live;

    // Producer counts only if it writes a real register.
    assign dst_live = dst_wr && (dst != ZERO_REG);

    always_comb begin
        hit.src_a = dst_live && src_a_rd && (src_a == dst);
        hit.src_b = dst_live && src_b_rd && (src_b == dst);
    end

    always_comb begin
        // R3: a non-writing producer never matches.
        a_r3_nowrite_no_hit: assert (dst_wr || !any_hit(hit));
        // R2: register zero never matches.
        a_r2_zero_no_hit: assert ((dst != ZERO_REG) || !any_hit(hit));
        // R4: unread sources never match.
        a_r4_unread_no_hit: assert ((src_a_rd || !hit.src_a) && (src_b_rd || !hit.src_b));
    end
endmodule

// File: rtl/hz_stall_policy.sv
module hz_stall_policy
    import hz_pkg::*;
#(
    parameter bit BYPASS_EN      = 1'b1,
    parameter bit RF_WRITE_FIRST = 1'b1
) (
    input  src_hit_t hit_ex,
    input  src_hit_t hit_mem,
    input  src_hit_t hit_wb,
    input  logic     ex_load,
    input  logic     flush,
    output logic     stall
);
    localparam bit NO_BYP   = !BYPASS_EN;
    localparam bit WB_LATE  = NO_BYP && !RF_WRITE_FIRST;

    logic need_ex, need_mem, need_wb, need;

    // Execute-stage producer: with bypassing only a load is too late.
    assign need_ex  = any_hit(hit_ex) && (ex_load || NO_BYP);
    // Memory-stage producer: bypass covers it when bypassing exists.
    assign need_mem = any_hit(hit_mem) && NO_BYP;
    // Writeback producer: only late if register file reads before writing.
    assign need_wb  = any_hit(hit_wb) && WB_LATE;

    assign need  = need_ex || need_mem || need_wb;
    assign stall = need && !flush;

    always_comb begin
        // R10: flush wins over any stall request.
        a_r10_flush_kills_stall: assert (!(flush && stall));
        // R6: with bypassing, only an execute-stage load stalls.
        a_r6_bypass_only_load: assert (NO_BYP || !stall || (ex_load && any_hit(hit_ex)));
    end
endmodule

// File: rtl/hz_bubble_mux.sv
module hz_bubble_mux #(
    parameter int CTRL_W = 8
) (
    input  logic              bubble,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] ctrl_out
);
    localparam logic [CTRL_W-1:0] NOP_CTRL = '0;

    always_comb begin
        ctrl_out = bubble ? NOP_CTRL : ctrl_in;
    end

    always_comb begin
        // R9: a bubble carries no control activity.
        a_r9_bubble_zero: assert (!bubble || (ctrl_out == NOP_CTRL));
    end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import hz_pkg::*;
#(
    parameter int REG_W          = 5,
    parameter int CTRL_W         = 8,
    parameter bit BYPASS_EN      = 1'b1,
    parameter bit RF_WRITE_FIRST = 1'b1
) (
    input  logic [REG_W-1:0]  id_rs1,
    input  logic [REG_W-1:0]  id_rs2,
    input  logic              id_rs1_rd,
    input  logic              id_rs2_rd,
    input  logic              id_flush,
    input  logic [CTRL_W-1:0] id_ctrl,
    input  logic [REG_W-1:0]  ex_rd,
    input  logic              ex_rf_wr,
    input  logic              ex_load,
    input  logic [REG_W-1:0]  mem_rd,
    input  logic              mem_rf_wr,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic              wb_rf_wr,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble,
    output logic [CTRL_W-1:0] idex_ctrl
);
    logic [REG_W-1:0] prod_dst [N_PROD];
    logic             prod_wr  [N_PROD];
    src_hit_t         prod_hit [N_PROD];
    logic             stall;

    assign prod_dst[PROD_EX]  = ex_rd;
    assign prod_wr[PROD_EX]   = ex_rf_wr;
    assign prod_dst[PROD_MEM] = mem_rd;
    assign prod_wr[PROD_MEM]  = mem_rf_wr;
    assign prod_dst[PROD_WB]  = wb_rd;
    assign prod_wr[PROD_WB]   = wb_rf_wr;

    // Six comparisons: each producer latch against both decode sources.
    for (genvar g = 0; g < N_PROD; g++) begin : g_cmp
        hz_cmp_slice #(.REG_W(REG_W)) u_cmp (
            .dst      (prod_dst[g]),
            .dst_wr   (prod_wr[g]),
            .src_a    (id_rs1),
            .src_a_rd (id_rs1_rd),
            .src_b    (id_rs2),
            .src_b_rd (id_rs2_rd),
            .hit      (prod_hit[g])
        );
    end

    hz_stall_policy #(
        .BYPASS_EN      (BYPASS_EN),
        .RF_WRITE_FIRST (RF_WRITE_FIRST)
    ) u_policy (
        .hit_ex  (prod_hit[PROD_EX]),
        .hit_mem (prod_hit[PROD_MEM]),
        .hit_wb  (prod_hit[PROD_WB]),
        .ex_load (ex_load),
        .flush   (id_flush),
        .stall   (stall)
    );

    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign idex_bubble = stall;

    hz_bubble_mux #(.CTRL_W(CTRL_W)) u_bubble (
        .bubble   (idex_bubble),
        .ctrl_in  (id_ctrl),
        .ctrl_out (idex_ctrl)
    );

    always_comb begin
        // R11: hold enables agree and oppose the bubble select.
        a_r11_hold_consistent: assert ((pc_we == ifid_we) && (idex_bubble != pc_we));
        // R1: a bubble only appears when some comparator matched.
        a_r1_bubble_needs_hit: assert (!idex_bubble ||
            any_hit(prod_hit[PROD_EX]) || any_hit(prod_hit[PROD_MEM]) || any_hit(prod_hit[PROD_WB]));
        // R9: with no bubble the decoded control passes unchanged.
        a_r9_pass_through: assert (idex_bubble || (idex_ctrl == id_ctrl));
    end
endmodule

// File: tb/raw_interlock_tb.sv
`timescale 1ns/1ps
module raw_interlock_tb;
    localparam int REG_W  = 5;
    localparam int CTRL_W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // Pipeline-latch model driving all three copies.
    logic [REG_W-1:0]  rs1, rs2, exd, memd, wbd;
    logic              rs1_rd, rs2_rd, flush, ex_wr, ex_ld, mem_wr, wb_wr;
    logic [CTRL_W-1:0] ctrl;

    logic b_pc, b_ifid, b_bub; logic [CTRL_W-1:0] b_ctrl;
    logic n0_pc, n0_ifid, n0_bub; logic [CTRL_W-1:0] n0_ctrl;
    logic n1_pc, n1_ifid, n1_bub; logic [CTRL_W-1:0] n1_ctrl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    raw_interlock #(.REG_W(REG_W), .CTRL_W(CTRL_W), .BYPASS_EN(1'b1), .RF_WRITE_FIRST(1'b1)) u_dut (
        .id_rs1(rs1), .id_rs2(rs2), .id_rs1_rd(rs1_rd), .id_rs2_rd(rs2_rd), .id_flush(flush),
        .id_ctrl(ctrl), .ex_rd(exd), .ex_rf_wr(ex_wr), .ex_load(ex_ld), .mem_rd(memd),
        .mem_rf_wr(mem_wr), .wb_rd(wbd), .wb_rf_wr(wb_wr),
        .pc_we(b_pc), .ifid_we(b_ifid), .idex_bubble(b_bub), .idex_ctrl(b_ctrl));

    raw_interlock #(.REG_W(REG_W), .CTRL_W(CTRL_W), .BYPASS_EN(1'b0), .RF_WRITE_FIRST(1'b0)) u_dut_nf0 (
        .id_rs1(rs1), .id_rs2(rs2), .id_rs1_rd(rs1_rd), .id_rs2_rd(rs2_rd), .id_flush(flush),
        .id_ctrl(ctrl), .ex_rd(exd), .ex_rf_wr(ex_wr), .ex_load(ex_ld), .mem_rd(memd),
        .mem_rf_wr(mem_wr), .wb_rd(wbd), .wb_rf_wr(wb_wr),
        .pc_we(n0_pc), .ifid_we(n0_ifid), .idex_bubble(n0_bub), .idex_ctrl(n0_ctrl));

    raw_interlock #(.REG_W(REG_W), .CTRL_W(CTRL_W), .BYPASS_EN(1'b0), .RF_WRITE_FIRST(1'b1)) u_dut_nf1 (
        .id_rs1(rs1), .id_rs2(rs2), .id_rs1_rd(rs1_rd), .id_rs2_rd(rs2_rd), .id_flush(flush),
        .id_ctrl(ctrl), .ex_rd(exd), .ex_rf_wr(ex_wr), .ex_load(ex_ld), .mem_rd(memd),
        .mem_rf_wr(mem_wr), .wb_rd(wbd), .wb_rf_wr(wb_wr),
        .pc_we(n1_pc), .ifid_we(n1_ifid), .idex_bubble(n1_bub), .idex_ctrl(n1_ctrl));

    // Check one copy against an expected stall value; all four outputs follow from it.
    task automatic chk(input string req, input string who, input logic pc, input logic ifid,
                       input logic bub, input logic [CTRL_W-1:0] co, input logic exp_stall);
        logic [CTRL_W-1:0] exp_ctrl;
        exp_ctrl = exp_stall ? '0 : ctrl;
        checks++;
        if (pc !== !exp_stall || ifid !== !exp_stall || bub !== exp_stall || co !== exp_ctrl) begin
            errors++;
            $display("FAIL %s %s: pc_we=%b ifid_we=%b bubble=%b ctrl=%h expected pc_we=%b ifid_we=%b bubble=%b ctrl=%h",
                     req, who, pc, ifid, bub, co, !exp_stall, !exp_stall, exp_stall, exp_ctrl);
        end
    endtask

    task automatic chk_all(input string req, input logic eb, input logic e0, input logic e1);
        #1;
        chk(req, "bypass",      b_pc,  b_ifid,  b_bub,  b_ctrl,  eb);
        chk(req, "nobyp_rdfst", n0_pc, n0_ifid, n0_bub, n0_ctrl, e0);
        chk(req, "nobyp_wrfst", n1_pc, n1_ifid, n1_bub, n1_ctrl, e1);
    endtask

    task automatic idle_pipe();
        @(negedge clk);
        rs1 = 5'd1; rs2 = 5'd2; rs1_rd = 1'b1; rs2_rd = 1'b1; flush = 1'b0; ctrl = 8'hA5;
        exd = 5'd10; ex_wr = 1'b0; ex_ld = 1'b0;
        memd = 5'd11; mem_wr = 1'b0; wbd = 5'd12; wb_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        idle_pipe();
        chk_all("R1_reset", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_no_match();
        idle_pipe();
        exd = 5'd3; ex_wr = 1'b1; ex_ld = 1'b1; memd = 5'd4; mem_wr = 1'b1; wbd = 5'd31; wb_wr = 1'b1;
        chk_all("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reg_zero();
        idle_pipe();
        rs1 = 5'd0; rs2 = 5'd0; exd = 5'd0; ex_wr = 1'b1; ex_ld = 1'b1;
        memd = 5'd0; mem_wr = 1'b1; wbd = 5'd0; wb_wr = 1'b1;
        chk_all("R2", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_store_producer();
        idle_pipe();
        exd = 5'd1; ex_wr = 1'b0; ex_ld = 1'b0; memd = 5'd2; mem_wr = 1'b0; wbd = 5'd1; wb_wr = 1'b0;
        chk_all("R3", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_unread_source();
        idle_pipe();
        rs2 = 5'd7; rs2_rd = 1'b0; exd = 5'd7; ex_wr = 1'b1; ex_ld = 1'b1;
        chk_all("R4_src2", 1'b0, 1'b0, 1'b0);
        rs1_rd = 1'b0; rs1 = 5'd9; memd = 5'd9; mem_wr = 1'b1;
        chk_all("R4_both", 1'b0, 1'b0, 1'b0);
    endtask

    // R5 then R7: load-use stalls once, then the load advances and a bubble fills execute.
    task automatic t_load_use();
        idle_pipe();
        rs1 = 5'd31; exd = 5'd31; ex_wr = 1'b1; ex_ld = 1'b1;
        chk_all("R5", 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        wbd = memd; wb_wr = mem_wr; memd = exd; mem_wr = ex_wr;
        exd = 5'd0; ex_wr = 1'b0; ex_ld = 1'b0;
        chk_all("R7", 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        wbd = memd; wb_wr = mem_wr; memd = exd; mem_wr = ex_wr;
        chk_all("R8_wb", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_alu_producer();
        idle_pipe();
        rs1 = 5'd5; exd = 5'd5; ex_wr = 1'b1; ex_ld = 1'b0;
        chk_all("R6_ex", 1'b0, 1'b1, 1'b1);
        idle_pipe();
        rs2 = 5'd6; memd = 5'd6; mem_wr = 1'b1;
        chk_all("R8_mem", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_second_source();
        idle_pipe();
        rs2 = 5'd20; exd = 5'd20; ex_wr = 1'b1; ex_ld = 1'b1; ctrl = 8'h3C;
        chk_all("R12", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_ctrl_pass();
        idle_pipe();
        ctrl = 8'hFF;
        chk_all("R9_pass", 1'b0, 1'b0, 1'b0);
        rs1 = 5'd4; exd = 5'd4; ex_wr = 1'b1; ex_ld = 1'b1;
        chk_all("R9_zero", 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_flush();
        idle_pipe();
        rs1 = 5'd8; exd = 5'd8; ex_wr = 1'b1; ex_ld = 1'b1; memd = 5'd8; mem_wr = 1'b1;
        flush = 1'b1; ctrl = 8'h5A;
        chk_all("R10", 1'b0, 1'b0, 1'b0);
        flush = 1'b0;
        chk_all("R11", 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_no_match();
        t_reg_zero();
        t_store_producer();
        t_unread_source();
        t_load_use();
        t_alu_producer();
        t_second_source();
        t_ctrl_pass();
        t_flush();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule